// File: doc/BRIEF.md
# Counter Group Command Decoder

This block turns byte-wide command writes into control pulses for a bank of five counter channels. It also holds a small set of device-wide mode flags. On each cycle where the write strobe is high, the byte on the command input is decoded, and the result appears one clock later.

Most opcodes are group commands. Their upper three bits pick the action, and their lower five bits form a channel mask in which bit 0 is channel 1 and bit 4 is channel 5. The remaining opcode space is for single-channel commands, which name one channel by a three-bit number (1 to 5) and either clear its toggle output, set it, or step it. The channel-number values that do not name a channel (0, 6 and 7) are reused as device commands. These commands update the mode flags or raise a master reset.

The counters, their registers and any data-pointer addressing sit outside this block. They consume the strobes and flags.

Top module: `ctr_cmd_decode`

## Requirements
- R1: After reset, every strobe output and `mreset_o` are 0, and every flag output is 0 (pointer sequencing enabled, FOUT driven, 8-bit bus, prefetch off).
- R2: A write whose bits [7:5] are 001, 010 or 110 drives `arm_o`, `load_o` or `disarm_o` respectively to bits [4:0] of the byte. The pulse appears in the cycle after the write and lasts exactly one cycle, and all other strobes stay 0.
- R3: Bits [7:5] = 011 drive both `load_o` and `arm_o` to the mask in the same cycle.
- R4: Bits [7:5] = 100 drive both `disarm_o` and `save_o` to the mask. Bits [7:5] = 101 drive only `save_o`.
- R5: Bits [7:3] = 11100, 11101 or 11110 with bits [2:0] = n in 1..5 pulse bit n-1 of `tog_clr_o`, `tog_set_o` or `step_o` respectively. At most one channel bit across these three outputs is ever high.
- R6: Byte 0xE8 sets `seq_dis_o`, and 0xE0 clears it.
- R7: Byte 0xEE sets `fout_off_o`, and 0xE6 clears it.
- R8: Byte 0xEF sets `bus16_o`, and 0xE7 clears it.
- R9: Byte 0xF8 sets `prefetch_o`, and 0xF9 clears it.
- R10: Byte 0xFF pulses `mreset_o` for one cycle, and in that same cycle all flags return to their R1 values.
- R11: Bytes 0xF0, 0xF6, 0xF7 and 0xFA through 0xFE have no effect: no strobe rises and no flag changes. Any byte with bits [7:5] = 000 also has no effect.
- R12: In a cycle without a write, no strobe is raised in the next cycle, whatever the command byte holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Command write strobe |
| cmd_i | input | 8 | Command byte |
| arm_o | output | 5 | Arm pulse per channel |
| load_o | output | 5 | Load pulse per channel |
| disarm_o | output | 5 | Disarm pulse per channel |
| save_o | output | 5 | Save-to-hold pulse per channel |
| step_o | output | 5 | Step pulse per channel |
| tog_set_o | output | 5 | Set-toggle pulse per channel |
| tog_clr_o | output | 5 | Clear-toggle pulse per channel |
| seq_dis_o | output | 1 | Data pointer sequencing disabled |
| fout_off_o | output | 1 | FOUT gated off |
| bus16_o | output | 1 | 16-bit bus mode |
| prefetch_o | output | 1 | Write prefetch enabled |
| mreset_o | output | 1 | Master reset pulse |

## Verification
The assertions check several properties on every cycle:
- strobes stay quiet and flags hold after an idle cycle;
- load-and-arm always pulses the same mask on both outputs;
- no single-channel command ever lights more than one channel;
- a master reset always leaves the flags at their defaults;
- a group code of 000 is inert.

Only the directed scenarios can confirm the exact mapping of each opcode to an output and a channel bit. The same holds for the flag set/clear pairs, the full list of reserved device bytes, and the one-cycle width of pulses from back-to-back writes.

// File: rtl/ctr_cmd_pkg.sv
package ctr_cmd_pkg;
  localparam int unsigned CMD_W   = 8;
  localparam int unsigned NUM_STB = 7;

  typedef enum logic [2:0] {
    GRP_NONE  = 3'd0,
    GRP_ARM   = 3'd1,
    GRP_LOAD  = 3'd2,
    GRP_LDARM = 3'd3,
    GRP_DSAVE = 3'd4,
    GRP_SAVE  = 3'd5,
    GRP_DIS   = 3'd6,
    GRP_EXT   = 3'd7
  } grp_e;

  typedef enum logic [1:0] {
    SGL_CLR  = 2'd0,
    SGL_SET  = 2'd1,
    SGL_STEP = 2'd2,
    SGL_DEV  = 2'd3
  } sgl_e;

  // strobe slot indices
  localparam int unsigned S_ARM  = 0;
  localparam int unsigned S_LOAD = 1;
  localparam int unsigned S_DIS  = 2;
  localparam int unsigned S_SAVE = 3;
  localparam int unsigned S_STEP = 4;
  localparam int unsigned S_TSET = 5;
  localparam int unsigned S_TCLR = 6;

  typedef struct packed {
    logic seq_clr;
    logic seq_set;
    logic fout_clr;
    logic fout_set;
    logic bus_clr;
    logic bus_set;
    logic pf_en;
    logic pf_dis;
    logic mreset;
  } dev_op_t;

  typedef struct packed {
    logic seq_dis;
    logic fout_off;
    logic bus16;
    logic prefetch;
  } flags_t;

  localparam flags_t FLAGS_DEFAULT = '0;
endpackage

// File: rtl/ctr_cmd_classify.sv
module ctr_cmd_classify
  import ctr_cmd_pkg::*;
#(
  parameter int unsigned N_CH = 5
) (
  input  logic                            valid_i,
  input  logic [CMD_W-1:0]                cmd_i,
  output logic [NUM_STB-1:0][N_CH-1:0]    stb_o,
  output dev_op_t                         dev_o
);
  localparam int unsigned SEL_W = 3;

  grp_e             grp;
  sgl_e             sgl;
  logic [SEL_W-1:0] sel;
  logic [N_CH-1:0]  mask;
  logic [N_CH-1:0]  ch_hot;

  assign grp  = grp_e'(cmd_i[7:5]);
  assign sgl  = sgl_e'(cmd_i[4:3]);
  assign sel  = cmd_i[SEL_W-1:0];
  assign mask = cmd_i[N_CH-1:0];

  // channel number n (1-based) -> bit n-1; 0, 6, 7 select nothing
  for (genvar i = 0; i < N_CH; i++) begin : g_hot
    assign ch_hot[i] = (sel == SEL_W'(i + 1));
  end

  always_comb begin
    stb_o = '0;
    dev_o = '0;
    if (valid_i) begin
      unique case (grp)
        GRP_ARM:   stb_o[S_ARM] = mask;
        GRP_LOAD:  stb_o[S_LOAD] = mask;
        GRP_LDARM: begin
          stb_o[S_ARM]  = mask;
          stb_o[S_LOAD] = mask;
        end
        GRP_DSAVE: begin
          stb_o[S_DIS]  = mask;
          stb_o[S_SAVE] = mask;
        end
        GRP_SAVE:  stb_o[S_SAVE] = mask;
        GRP_DIS:   stb_o[S_DIS] = mask;
        GRP_EXT: begin
          unique case (sgl)
            SGL_CLR: begin
              if (sel == 3'd0)      dev_o.seq_clr = 1'b1;
              else if (sel == 3'd6) dev_o.fout_clr = 1'b1;
              else if (sel == 3'd7) dev_o.bus_clr = 1'b1;
              else                  stb_o[S_TCLR] = ch_hot;
            end
            SGL_SET: begin
              if (sel == 3'd0)      dev_o.seq_set = 1'b1;
              else if (sel == 3'd6) dev_o.fout_set = 1'b1;
              else if (sel == 3'd7) dev_o.bus_set = 1'b1;
              else                  stb_o[S_TSET] = ch_hot;
            end
            SGL_STEP: stb_o[S_STEP] = ch_hot;
            SGL_DEV: begin
              case (sel)
                3'd0:    dev_o.pf_en = 1'b1;
                3'd1:    dev_o.pf_dis = 1'b1;
                3'd7:    dev_o.mreset = 1'b1;
                default: ;
              endcase
            end
            default: ;
          endcase
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ctr_cmd_strobes.sv
module ctr_cmd_strobes
  import ctr_cmd_pkg::*;
#(
  parameter int unsigned N_CH = 5
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [NUM_STB-1:0][N_CH-1:0] stb_d_i,
  output logic [NUM_STB-1:0][N_CH-1:0] stb_q_o
);
  for (genvar k = 0; k < NUM_STB; k++) begin : g_stb
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stb_q_o[k] <= '0;
      else         stb_q_o[k] <= stb_d_i[k];
    end
  end
endmodule

// File: rtl/ctr_cmd_flags.sv
module ctr_cmd_flags
  import ctr_cmd_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  dev_op_t dev_i,
  output flags_t  flags_o,
  output logic    mreset_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_o  <= FLAGS_DEFAULT;
      mreset_o <= 1'b0;
    end else begin
      mreset_o <= dev_i.mreset;
      if (dev_i.mreset) begin
        flags_o <= FLAGS_DEFAULT;
      end else begin
        if (dev_i.seq_set)  flags_o.seq_dis  <= 1'b1;
        if (dev_i.seq_clr)  flags_o.seq_dis  <= 1'b0;
        if (dev_i.fout_set) flags_o.fout_off <= 1'b1;
        if (dev_i.fout_clr) flags_o.fout_off <= 1'b0;
        if (dev_i.bus_set)  flags_o.bus16    <= 1'b1;
        if (dev_i.bus_clr)  flags_o.bus16    <= 1'b0;
        if (dev_i.pf_en)    flags_o.prefetch <= 1'b1;
        if (dev_i.pf_dis)   flags_o.prefetch <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ctr_cmd_decode.sv
module ctr_cmd_decode
  import ctr_cmd_pkg::*;
#(
  parameter int unsigned N_CH = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [CMD_W-1:0] cmd_i,
  output logic [N_CH-1:0]  arm_o,
  output logic [N_CH-1:0]  load_o,
  output logic [N_CH-1:0]  disarm_o,
  output logic [N_CH-1:0]  save_o,
  output logic [N_CH-1:0]  step_o,
  output logic [N_CH-1:0]  tog_set_o,
  output logic [N_CH-1:0]  tog_clr_o,
  output logic             seq_dis_o,
  output logic             fout_off_o,
  output logic             bus16_o,
  output logic             prefetch_o,
  output logic             mreset_o
);
  logic [NUM_STB-1:0][N_CH-1:0] stb_d, stb_q;
  dev_op_t                      dev_op;
  flags_t                       flags;

  ctr_cmd_classify #(.N_CH(N_CH)) i_classify (
    .valid_i (wr_i),
    .cmd_i   (cmd_i),
    .stb_o   (stb_d),
    .dev_o   (dev_op)
  );

  ctr_cmd_strobes #(.N_CH(N_CH)) i_strobes (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .stb_d_i (stb_d),
    .stb_q_o (stb_q)
  );

  ctr_cmd_flags i_flags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .dev_i    (dev_op),
    .flags_o  (flags),
    .mreset_o (mreset_o)
  );

  assign arm_o      = stb_q[S_ARM];
  assign load_o     = stb_q[S_LOAD];
  assign disarm_o   = stb_q[S_DIS];
  assign save_o     = stb_q[S_SAVE];
  assign step_o     = stb_q[S_STEP];
  assign tog_set_o  = stb_q[S_TSET];
  assign tog_clr_o  = stb_q[S_TCLR];
  assign seq_dis_o  = flags.seq_dis;
  assign fout_off_o = flags.fout_off;
  assign bus16_o    = flags.bus16;
  assign prefetch_o = flags.prefetch;

  logic quiet;
  assign quiet = (arm_o == '0) && (load_o == '0) && (disarm_o == '0) && (save_o == '0) &&
                 (step_o == '0) && (tog_set_o == '0) && (tog_clr_o == '0) && !mreset_o;

  assert_idle_quiet_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> quiet);

  assert_idle_flags_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable({seq_dis_o, fout_off_o, bus16_o, prefetch_o}));

  assert_null_group_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && cmd_i[7:5] == 3'b000) |=>
      (quiet && $stable({seq_dis_o, fout_off_o, bus16_o, prefetch_o})));

  assert_ldarm_pair_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && cmd_i[7:5] == 3'b011) |=>
      (arm_o == load_o && arm_o == $past(cmd_i[N_CH-1:0])));

  assert_mreset_defaults_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && cmd_i == 8'hFF) |=>
      (mreset_o && !seq_dis_o && !fout_off_o && !bus16_o && !prefetch_o));

  assert_one_chan_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(step_o | tog_set_o | tog_clr_o));
endmodule

// File: tb/test_ctr_cmd_decode.sv
`timescale 1ns/1ps
module test_ctr_cmd_decode;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_i = 1'b0;
  logic [7:0] cmd_i = 8'h00;
  logic [4:0] arm_o, load_o, disarm_o, save_o, step_o, tog_set_o, tog_clr_o;
  logic       seq_dis_o, fout_off_o, bus16_o, prefetch_o, mreset_o;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk_i = ~clk_i;

  ctr_cmd_decode i_ctr_cmd_decode (
    .clk_i, .rst_ni, .wr_i, .cmd_i,
    .arm_o, .load_o, .disarm_o, .save_o, .step_o, .tog_set_o, .tog_clr_o,
    .seq_dis_o, .fout_off_o, .bus16_o, .prefetch_o, .mreset_o
  );

  task automatic chk(input string req, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // strobes order: arm load disarm save step set clr mreset
  task automatic chk_stb(input string req, input logic [4:0] a, l, d, s, st, ts, tc,
                         input logic mr);
    chk(req, "strobes", {arm_o, load_o, disarm_o, save_o, step_o, tog_set_o, tog_clr_o, mreset_o},
        {a, l, d, s, st, ts, tc, mr});
  endtask

  task automatic chk_flags(input string req, input logic [3:0] exp);
    chk(req, "flags", {60'd0, seq_dis_o, fout_off_o, bus16_o, prefetch_o}, {60'd0, exp});
  endtask

  // write at one edge, leave sampling point at the following negedge
  task automatic send(input logic [7:0] c);
    @(negedge clk_i);
    wr_i  = 1'b1;
    cmd_i = c;
    @(negedge clk_i);
    wr_i  = 1'b0;
  endtask

  task automatic t_reset;
    chk_stb("R1", 0, 0, 0, 0, 0, 0, 0, 0);
    chk_flags("R1", 4'b0000);
  endtask

  task automatic t_mask_groups;
    logic [4:0] masks [3] = '{5'b10101, 5'b01010, 5'b11111};
    foreach (masks[i]) begin
      send({3'b001, masks[i]}); chk_stb("R2", masks[i], 0, 0, 0, 0, 0, 0, 0);
      @(negedge clk_i);        chk_stb("R2", 0, 0, 0, 0, 0, 0, 0, 0);
      send({3'b010, masks[i]}); chk_stb("R2", 0, masks[i], 0, 0, 0, 0, 0, 0);
      send({3'b110, masks[i]}); chk_stb("R2", 0, 0, masks[i], 0, 0, 0, 0, 0);
    end
    // back-to-back writes: each pulse only one cycle
    @(negedge clk_i); wr_i = 1'b1; cmd_i = 8'h23;
    @(negedge clk_i); cmd_i = 8'h4C;
    chk_stb("R2", 5'h03, 0, 0, 0, 0, 0, 0, 0);
    @(negedge clk_i); wr_i = 1'b0;
    chk_stb("R2", 0, 5'h0C, 0, 0, 0, 0, 0, 0);
    @(negedge clk_i); chk_stb("R2", 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_ldarm;
    send(8'h67); chk_stb("R3", 5'h07, 5'h07, 0, 0, 0, 0, 0, 0);
    send(8'h71); chk_stb("R3", 5'h11, 5'h11, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_disarm_save;
    send({3'b100, 5'b11001}); chk_stb("R4", 0, 0, 5'b11001, 5'b11001, 0, 0, 0, 0);
    send({3'b101, 5'b00110}); chk_stb("R4", 0, 0, 0, 5'b00110, 0, 0, 0, 0);
  endtask

  task automatic t_single;
    for (int ch = 1; ch <= 5; ch++) begin
      logic [4:0] h;
      h = 5'(1 << (ch - 1));
      send(8'hE0 | 8'(ch)); chk_stb("R5", 0, 0, 0, 0, 0, 0, h, 0);
      send(8'hE8 | 8'(ch)); chk_stb("R5", 0, 0, 0, 0, 0, h, 0, 0);
      send(8'hF0 | 8'(ch)); chk_stb("R5", 0, 0, 0, 0, h, 0, 0, 0);
    end
    chk_flags("R5", 4'b0000);
  endtask

  task automatic t_flags;
    send(8'hE8); chk_flags("R6", 4'b1000); chk_stb("R6", 0, 0, 0, 0, 0, 0, 0, 0);
    send(8'hE0); chk_flags("R6", 4'b0000);
    send(8'hEE); chk_flags("R7", 4'b0100);
    send(8'hE6); chk_flags("R7", 4'b0000);
    send(8'hEF); chk_flags("R8", 4'b0010);
    send(8'hE7); chk_flags("R8", 4'b0000);
    send(8'hF8); chk_flags("R9", 4'b0001);
    send(8'hF9); chk_flags("R9", 4'b0000);
  endtask

  task automatic t_mreset;
    send(8'hE8); send(8'hEE); send(8'hEF); send(8'hF8);
    chk_flags("R10", 4'b1111);
    send(8'hFF);
    chk_stb("R10", 0, 0, 0, 0, 0, 0, 0, 1);
    chk_flags("R10", 4'b0000);
    @(negedge clk_i); chk_stb("R10", 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_ignored;
    logic [7:0] junk [11] = '{8'hF0, 8'hF6, 8'hF7, 8'hFA, 8'hFB, 8'hFC, 8'hFD, 8'hFE,
                              8'h00, 8'h1F, 8'h15};
    send(8'hE8); send(8'hF8);
    foreach (junk[i]) begin
      send(junk[i]);
      chk_stb("R11", 0, 0, 0, 0, 0, 0, 0, 0);
      chk_flags("R11", 4'b1001);
    end
    send(8'hFF);
  endtask

  task automatic t_idle;
    @(negedge clk_i); cmd_i = 8'h3F;
    repeat (3) begin
      @(negedge clk_i); chk_stb("R12", 0, 0, 0, 0, 0, 0, 0, 0);
    end
    cmd_i = 8'hFF;
    @(negedge clk_i); chk_stb("R12", 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_mask_groups();
    t_ldarm();
    t_disarm_save();
    t_single();
    t_flags();
    t_mreset();
    t_ignored();
    t_idle();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule